// File: doc/BRIEF.md
# Serial Flash Page-Rewrite Sequencer

This block is the host side of a four-wire serial link to a page-organised flash memory. A one-cycle start request, together with a buffer choice, a 12-bit page number and a page-size mode, makes it send a rewrite command. That command is one opcode byte followed by a 24-bit address. The block then raises chip select, which tells the flash to begin its internal copy-and-reprogram cycle.

After a minimum chip-select high time, the block opens a second chip-select window. It sends the status-read opcode and then clocks status bytes back over and over without releasing chip select. It stops when the flash reports ready, or when a poll limit given at start is used up. On a normal finish it pulses `done`; if the limit runs out it pulses `timeout` instead.

The serial clock is derived from the system clock with a parameterised half period, and the link uses SPI mode 0. `busy` covers the whole operation, and any start request seen while `busy` is high is dropped.

Top module: `flash_rewrite_seq`

## Requirements
- R1: The first byte of the command window is 0x58 when `buf_sel` is 0 and 0x59 when `buf_sel` is 1.
- R2: With `bin_page` = 0, the 24-bit address sent MSB first after the opcode carries `page` in bits 21..10, and every other address bit is 0.
- R3: With `bin_page` = 1, the 24-bit address carries `page` in bits 20..9, and every other address bit is 0.
- R4: The command window contains exactly 32 rising SCK edges (opcode plus three address bytes). `cs_n` goes high at the end of that window.
- R5: Between the command window and the polling window, `cs_n` stays high for at least CS_GAP system clocks.
- R6: The polling window opens with 0xD7. The block then reads status bytes inside that one window until it reads a byte with bit 7 equal to 1. It then raises `cs_n` and pulses `done` for exactly one cycle.
- R7: If `poll_limit` status bytes have been read and all show bit 7 equal to 0, the block raises `cs_n` and pulses `timeout` for one cycle, with no `done`. A `poll_limit` of 0 acts as 1.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `timeout` is high, when it is low. A start request while `busy` is high changes neither the bytes sent nor the number of windows, and starts no new operation.
- R9: SPI mode 0 is used. SCK is low whenever `cs_n` is high, MOSI is stable across each rising SCK edge, and each SCK high phase lasts SCK_HALF system clocks.
- R10: While reset is held, the outputs are `cs_n`=1, `sck`=0, `mosi`=0, `busy`=0, `done`=0 and `timeout`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a rewrite |
| buf_sel | input | 1 | 0 selects buffer 1, 1 selects buffer 2 |
| page | input | 12 | Page number to rewrite |
| bin_page | input | 1 | 1 = 512-byte page layout, 0 = 528-byte layout |
| poll_limit | input | POLL_W | Maximum number of status bytes to read |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the flash reports ready |
| timeout | output | 1 | One-cycle pulse when the poll limit is exhausted |

## Verification
The hardest case to reach is the boundary of the poll loop, where the ready byte arrives on the last status byte the limit allows, or one byte too late. The bench uses a behavioural flash on the serial pins that reports busy for a programmed number of status bytes. The stimulus table then pairs busy counts with limits that sit exactly on either side of that edge, including a zero limit. A start request injected in the middle of a command shows the drop rule: the captured address and the window count stay the same.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;

    localparam logic [7:0] OPC_REWRITE_B1 = 8'h58;
    localparam logic [7:0] OPC_REWRITE_B2 = 8'h59;
    localparam logic [7:0] OPC_STATUS_RD  = 8'hD7;
    localparam logic [7:0] FILL_BYTE      = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_RD
    } seq_state_t;

    typedef struct packed {
        logic        buf2;
        logic [11:0] page;
        logic        bin_mode;
    } rw_req_t;

    function automatic logic [23:0] rw_address(input rw_req_t r);
        if (r.bin_mode)
            return {3'b000, r.page, 9'b0};
        else
            return {2'b00, r.page, 10'b0};
    endfunction

    function automatic logic [7:0] cmd_byte(input rw_req_t r, input logic [1:0] idx);
        logic [23:0] a;
        a = rw_address(r);
        case (idx)
            2'd0:    return r.buf2 ? OPC_REWRITE_B2 : OPC_REWRITE_B1;
            2'd1:    return a[23:16];
            2'd2:    return a[15:8];
            default: return a[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCK_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       byte_done
);
    logic       active;
    logic       tick;
    logic [7:0] sh;
    logic [2:0] bit_idx;

    spi_tick_gen #(.SCK_HALF(SCK_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (active),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            sck       <= 1'b0;
            mosi      <= 1'b0;
            sh        <= '0;
            rx        <= '0;
            bit_idx   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    sh      <= tx;
                    mosi    <= tx[7];
                    bit_idx <= '0;
                    sck     <= 1'b0;
                end
            end else if (tick) begin
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sh      <= {sh[6:0], 1'b0};
                        mosi    <= sh[6];
                    end
                end
            end
        end
    end

    AST_MOSI_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(mosi)); // R9
    AST_SCK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |-> !sck); // R9
endmodule

// File: rtl/flash_rewrite_seq.sv
module flash_rewrite_seq
    import flash_rw_pkg::*;
#(
    parameter int SCK_HALF = 2,
    parameter int CS_GAP   = 4,
    parameter int POLL_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              buf_sel,
    input  logic [11:0]       page,
    input  logic              bin_page,
    input  logic [POLL_W-1:0] poll_limit,
    input  logic              miso,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
    localparam int HI_W = $clog2(CS_GAP + 2) + 1;

    seq_state_t        state;
    rw_req_t           req_q;
    rw_req_t           req_in;
    logic [1:0]        byte_idx;
    logic [GAP_W-1:0]  gap_cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic [POLL_W-1:0] lim_q;
    logic              go;
    logic [7:0]        tx;
    logic [7:0]        rx;
    logic              byte_done;
    logic              last_poll;

    assign req_in    = '{buf2: buf_sel, page: page, bin_mode: bin_page};
    assign last_poll = ({1'b0, poll_cnt} + 1'b1) == {1'b0, lim_q};

    spi_byte_engine #(.SCK_HALF(SCK_HALF)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .tx        (tx),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .rx        (rx),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            byte_idx <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            lim_q    <= '0;
            go       <= 1'b0;
            tx       <= '0;
            cs_n     <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b0;
            timeout  <= 1'b0;
        end else begin
            go      <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q    <= req_in;
                        lim_q    <= (poll_limit == '0) ? POLL_W'(1) : poll_limit;
                        busy     <= 1'b1;
                        cs_n     <= 1'b0;
                        go       <= 1'b1;
                        tx       <= cmd_byte(req_in, 2'd0);
                        byte_idx <= 2'd0;
                        state    <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (byte_done) begin
                        if (byte_idx == 2'd3) begin
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            go       <= 1'b1;
                            tx       <= cmd_byte(req_q, byte_idx + 1'b1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        cs_n     <= 1'b0;
                        go       <= 1'b1;
                        tx       <= OPC_STATUS_RD;
                        poll_cnt <= '0;
                        state    <= ST_POLL_OP;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                ST_POLL_OP: begin
                    if (byte_done) begin
                        go    <= 1'b1;
                        tx    <= FILL_BYTE;
                        state <= ST_POLL_RD;
                    end
                end
                ST_POLL_RD: begin
                    if (byte_done) begin
                        if (rx[7]) begin
                            cs_n  <= 1'b1;
                            done  <= 1'b1;
                            busy  <= 1'b0;
                            state <= ST_IDLE;
                        end else if (last_poll) begin
                            cs_n    <= 1'b1;
                            timeout <= 1'b1;
                            busy    <= 1'b0;
                            state   <= ST_IDLE;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                            go       <= 1'b1;
                            tx       <= FILL_BYTE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // checker state: length of the current chip-select high run
    logic [HI_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '0;
        else if (!cs_n)
            hi_run <= '0;
        else if (hi_run != '1)
            hi_run <= hi_run + 1'b1;
    end

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && state == ST_POLL_OP) |-> (hi_run >= HI_W'(CS_GAP))); // R5
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n); // R6
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q)); // R8
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || timeout)); // R8
endmodule

// File: tb/flash_rewrite_seq_tb.sv
module flash_rewrite_seq_tb;
    localparam int SCK_HALF = 2;
    localparam int CS_GAP   = 4;
    localparam int POLL_W   = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              buf_sel = 1'b0;
    logic [11:0]       page = '0;
    logic              bin_page = 1'b0;
    logic [POLL_W-1:0] poll_limit = '0;
    logic              miso = 1'b0;
    logic              sck, cs_n, mosi, busy, done, timeout;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_rewrite_seq #(.SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP), .POLL_W(POLL_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .buf_sel(buf_sel), .page(page),
        .bin_page(bin_page), .poll_limit(poll_limit), .miso(miso),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done), .timeout(timeout)
    );

    // behavioural flash on the serial pins
    int         bitcnt = 0;
    int         win_no = 0;
    int         busy_n = 0;
    logic [7:0] shin = '0;
    logic [7:0] win_bytes [0:63];
    logic [7:0] cmd_b [0:3];
    int         cmd_bits = 0;
    logic [7:0] poll_op = '0;
    int         poll_bits = 0;

    always @(negedge cs_n) bitcnt = 0;

    always @(posedge sck) if (!cs_n) begin
        shin = {shin[6:0], mosi};
        bitcnt++;
        if (bitcnt % 8 == 0 && bitcnt / 8 <= 64) win_bytes[bitcnt/8-1] = shin;
    end

    always @(negedge sck) if (!cs_n && win_no == 1 && bitcnt >= 8) begin
        automatic int k = (bitcnt - 8) / 8;
        automatic int pos = 7 - ((bitcnt - 8) % 8);
        automatic logic [7:0] st = (k >= busy_n) ? 8'h8C : 8'h4C;
        miso = st[pos];
    end

    always @(posedge cs_n) if (!rst) begin
        if (win_no == 0) begin
            for (int i = 0; i < 4; i++) cmd_b[i] = win_bytes[i];
            cmd_bits = bitcnt;
        end else if (win_no == 1) begin
            poll_op = win_bytes[0];
            poll_bits = bitcnt;
        end
        win_no++;
    end

    // pin monitors sampled away from the active edge
    int gap_cycles = 0, done_cnt = 0, to_cnt = 0, sck_hi = 0, sck_bad = 0, sck_desel = 0, cs_low_after = 0;
    bit watch_after = 0;
    always @(negedge clk) if (!rst) begin
        if (win_no == 1 && cs_n) gap_cycles++;
        if (done) done_cnt++;
        if (timeout) to_cnt++;
        if (cs_n && sck) sck_desel++;
        if (sck) sck_hi++;
        else if (sck_hi > 0) begin
            if (sck_hi != SCK_HALF) sck_bad++;
            sck_hi = 0;
        end
        if (watch_after && !cs_n) cs_low_after++;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // buf(1) mode(1) page(12) limit(8) busy_n(8)
    localparam int NV = 6;
    localparam logic [29:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 12'h000, 8'd8, 8'd0},
        {1'b1, 1'b0, 12'hFFF, 8'd8, 8'd3},
        {1'b0, 1'b1, 12'hA5C, 8'd8, 8'd2},
        {1'b1, 1'b1, 12'h123, 8'd5, 8'd4},
        {1'b0, 1'b0, 12'h801, 8'd3, 8'd3},
        {1'b1, 1'b1, 12'h7FE, 8'd0, 8'd5}
    };

    task automatic run_op(input logic b, input logic m, input logic [11:0] pg,
                          input logic [7:0] lim, input int bn, input bit poke);
        logic [23:0] exp_addr;
        int eff, exp_reads, n;
        bit exp_done, ended;
        exp_addr = m ? {3'b000, pg, 9'b0} : {2'b00, pg, 10'b0};
        eff = (lim == 0) ? 1 : lim;
        exp_done = (bn < eff);
        exp_reads = exp_done ? bn + 1 : eff;
        busy_n = bn; win_no = 0; gap_cycles = 0; done_cnt = 0; to_cnt = 0;
        cmd_bits = 0; poll_bits = 0; watch_after = 0; cs_low_after = 0;
        @(negedge clk);
        buf_sel = b; bin_page = m; page = pg; poll_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", "busy after start", busy, 1);
        n = 0; ended = 0;
        while (!ended && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && n == 20) begin
                buf_sel = ~b; page = ~pg; bin_page = ~m; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (done || timeout) ended = 1;
        end
        check(ended, "R6", "operation ended before watchdog", ended, 1);
        check(busy == 1'b0, "R8", "busy low at end pulse", busy, 0);
        watch_after = 1;
        repeat (40) @(negedge clk);
        watch_after = 0;
        check(cmd_b[0] == (b ? 8'h59 : 8'h58), "R1", "opcode", cmd_b[0], b ? 8'h59 : 8'h58);
        check({cmd_b[1], cmd_b[2], cmd_b[3]} == exp_addr, m ? "R3" : "R2", "address",
              {cmd_b[1], cmd_b[2], cmd_b[3]}, exp_addr);
        check(cmd_bits == 32, "R4", "command window bits", cmd_bits, 32);
        check(win_no == 2, "R8", "window count", win_no, 2);
        check(gap_cycles >= CS_GAP, "R5", "cs high gap", gap_cycles, CS_GAP);
        check(poll_op == 8'hD7, "R6", "status opcode", poll_op, 8'hD7);
        check(poll_bits == 8 + 8 * exp_reads, exp_done ? "R6" : "R7", "status bits polled",
              poll_bits, 8 + 8 * exp_reads);
        check(done_cnt == (exp_done ? 1 : 0), "R6", "done pulses", done_cnt, exp_done ? 1 : 0);
        check(to_cnt == (exp_done ? 0 : 1), "R7", "timeout pulses", to_cnt, exp_done ? 0 : 1);
        check(cs_low_after == 0, "R8", "no new window after end", cs_low_after, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R10", "reset cs_n", cs_n, 1);
        check(sck == 1'b0 && mosi == 1'b0, "R10", "reset sck/mosi", {sck, mosi}, 0);
        check(busy == 1'b0 && done == 1'b0 && timeout == 1'b0, "R10", "reset flags",
              {busy, done, timeout}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < NV; i++)
            run_op(VEC[i][29], VEC[i][28], VEC[i][27:16], VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);
        // start request during an active command must be dropped
        run_op(1'b0, 1'b1, 12'h3C6, 8'd6, 1, 1'b1);
        check(sck_bad == 0, "R9", "sck high-phase length errors", sck_bad, 0);
        check(sck_desel == 0, "R9", "sck high while deselected", sck_desel, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule